// File: doc/BRIEF.md
# Reduced-Feature Serial Transceiver Core

This block is a small asynchronous serial port. It turns bytes pushed into an eight-entry transmit queue into frames on `txd`, and it rebuilds frames seen on `rxd` into bytes held in an eight-entry receive queue. Each frame is one low start bit, then 7 or 8 data bits with the least significant bit first, then one high stop bit. There is no parity and no framing check. The bit rate comes straight from the system clock. A divisor produces one tick every `cfg_div` clocks, and each bit lasts eight ticks.

The surrounding register block drives the configuration inputs and moves bytes through the push/pop ports. The transmitter and the receiver each have their own enable. A break input forces the line low. `rts` either follows a software request or, in automatic mode, drops once the receive queue reaches a programmed fill. In automatic mode the transmitter also waits for `cts` before it begins a frame. A byte that arrives while the receive queue is full is lost, and a sticky overrun flag records the loss until status is read.

Top module: `mu_serial_core`

## Requirements
- R1: After reset `txd` is 1, both queues are empty (`rx_valid`=0, `tx_full`=0, `tx_idle`=1) and `overrun` is 0.
- R2: A frame is a start bit of 0, then the data bits least significant first, then one stop bit of 1, with no parity. Every bit lasts 8×`cfg_div` clocks, and a divisor of 0 acts as 1.
- R3: With `cfg_len8`=0 the frame carries 7 data bits. Bit 7 of the pushed byte is not sent, and bit 7 of a received byte reads 0.
- R4: The transmit queue holds 8 bytes. `tx_full` is 1 at 8, `tx_level` reports the fill, and a push while full is dropped.
- R5: Received bytes appear at `rx_data` in arrival order while `rx_valid` is 1. `rx_pop` advances to the next byte, and `rx_level` reports the fill (0..8).
- R6: A byte that completes while the receive queue holds 8 is discarded and sets `overrun`. The flag stays set until a cycle with `stat_rd`=1.
- R7: While `brk` is 1, `txd` is 0.
- R8: With `afc_rx`=0, `rts` equals `rts_sw`. With `afc_rx`=1, `rts` is 1 while `rx_level` < `afc_level` and 0 once it reaches it.
- R9: With `afc_tx`=1 and `cts`=0 no new frame starts. The queued byte is sent once `cts` returns to 1.
- R10: With `tx_en`=0 no frame starts and `txd` stays 1. With `rx_en`=0 frames on `rxd` are ignored.
- R11: The receiver confirms a start bit half a bit after the falling edge. A low pulse shorter than that yields no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | 16 | Clocks per tick; bit = 8 ticks |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| brk | input | 1 | Force line low |
| rts_sw | input | 1 | Software RTS value |
| afc_rx | input | 1 | Automatic RTS from receive fill |
| afc_tx | input | 1 | Transmitter waits for CTS |
| afc_level | input | 4 | Fill at which automatic RTS drops |
| cts | input | 1 | Clear-to-send, 1 = may send |
| tx_push | input | 1 | Write `tx_data` into transmit queue |
| tx_data | input | 8 | Byte to send |
| tx_full | output | 1 | Transmit queue full |
| tx_level | output | 4 | Transmit queue fill |
| tx_idle | output | 1 | Queue empty and no frame in flight |
| rx_pop | input | 1 | Remove head of receive queue |
| rx_data | output | 8 | Head of receive queue |
| rx_valid | output | 1 | Receive queue not empty |
| rx_level | output | 4 | Receive queue fill |
| stat_rd | input | 1 | Status read; clears overrun |
| overrun | output | 1 | Sticky receive overrun |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| rts | output | 1 | Request-to-send, 1 = asserted |

## Verification
The line-level results are due many cycles after a push. A frame can start only on a tick, so it begins up to `cfg_div` clocks after the push. A received byte lands in the queue at the centre of its stop bit. The bench therefore measures pulse widths on `txd` in clocks between edges, and it waits on `rx_valid` or `rx_level` with a bounded poll rather than at fixed offsets. The combinational results `rts`, `rx_data`, `tx_full` and the break on `txd` are checked one falling clock edge after the input or queue change that causes them, and `overrun` one edge after the completing frame or the `stat_rd` cycle.

// File: rtl/mu_pkg.sv
package mu_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  // Number of data bits carried by a frame.
  function automatic logic [3:0] data_bits(input logic len8);
    return len8 ? 4'd8 : 4'd7;
  endfunction

  // Index of the stop bit within the frame (start bit is index 0).
  function automatic logic [3:0] stop_index(input logic len8);
    return data_bits(len8) + 4'd1;
  endfunction

  // Bits after the start bit, LSB first order, stop bit(s) at the top.
  function automatic logic [8:0] frame_tail(input logic [7:0] b, input logic len8);
    return len8 ? {1'b1, b} : {2'b11, b[6:0]};
  endfunction

  // Align a received shift register to the byte seen by the consumer.
  function automatic logic [7:0] rx_align(input logic [7:0] sh, input logic len8);
    return len8 ? sh : {1'b0, sh[7:1]};
  endfunction

endpackage

// File: rtl/mu_baud.sv
module mu_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim  = (div == '0) ? '0 : div - 1'b1;
  assign tick = (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  p_tick_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == '0));
endmodule

// File: rtl/mu_fifo.sv
module mu_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full);
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);
endmodule

// File: rtl/mu_tx.sv
module mu_tx
  import mu_pkg::*;
#(
  parameter int OSR = 8,
  localparam int OW = $clog2(OSR)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       tx_en,
  input  logic       len8,
  input  logic       afc_tx,
  input  logic       cts,
  input  logic       q_empty,
  input  logic [7:0] q_data,
  output logic       tx_start,
  output logic       busy,
  output logic       line
);
  logic [8:0]    sh;
  logic [3:0]    bitn;
  logic [OW-1:0] sub;
  logic          may_send;

  assign may_send = tx_en && !q_empty && (!afc_tx || cts);
  assign tx_start = tick && !busy && may_send;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sh   <= '1;
      bitn <= '0;
      sub  <= '0;
      line <= 1'b1;
    end else if (tx_start) begin
      busy <= 1'b1;
      sh   <= frame_tail(q_data, len8);
      bitn <= '0;
      sub  <= '0;
      line <= 1'b0;
    end else if (busy && tick) begin
      if (sub == OW'(OSR - 1)) begin
        sub <= '0;
        if (bitn == stop_index(len8)) begin
          busy <= 1'b0;
          line <= 1'b1;
        end else begin
          bitn <= bitn + 1'b1;
          line <= sh[0];
          sh   <= {1'b1, sh[8:1]};
        end
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

  p_line_idle_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> line);
  p_bit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(line));
endmodule

// File: rtl/mu_rx.sv
module mu_rx
  import mu_pkg::*;
#(
  parameter int OSR = 8,
  localparam int OW = $clog2(OSR)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_en,
  input  logic       len8,
  input  logic       rxd_s,
  output logic       push,
  output logic [7:0] push_data
);
  rx_state_e     st;
  logic [7:0]    sh;
  logic [3:0]    bitn;
  logic [OW-1:0] sub;
  logic          at_half, at_full;

  assign at_half   = (sub == OW'(OSR / 2 - 1));
  assign at_full   = (sub == OW'(OSR - 1));
  assign push      = rx_en && tick && (st == RX_STOP) && at_full;
  assign push_data = rx_align(sh, len8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= RX_IDLE;
      sh   <= '0;
      bitn <= '0;
      sub  <= '0;
    end else if (!rx_en) begin
      st  <= RX_IDLE;
      sub <= '0;
    end else if (tick) begin
      case (st)
        RX_IDLE: begin
          sub <= '0;
          if (!rxd_s) st <= RX_START;
        end
        RX_START: begin
          if (at_half) begin
            sub  <= '0;
            bitn <= '0;
            st   <= rxd_s ? RX_IDLE : RX_DATA;
          end else begin
            sub <= sub + 1'b1;
          end
        end
        RX_DATA: begin
          if (at_full) begin
            sub <= '0;
            sh  <= {rxd_s, sh[7:1]};
            if (bitn == data_bits(len8) - 4'd1) st <= RX_STOP;
            else bitn <= bitn + 1'b1;
          end else begin
            sub <= sub + 1'b1;
          end
        end
        RX_STOP: begin
          if (at_full) begin
            sub <= '0;
            st  <= RX_IDLE;
          end else begin
            sub <= sub + 1'b1;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  p_rx_off_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (st == RX_IDLE));
  p_push_only_enabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> rx_en);
endmodule

// File: rtl/mu_serial_core.sv
module mu_serial_core
  import mu_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DIV_W = 16,
  parameter int OSR   = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_len8,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             brk,
  input  logic             rts_sw,
  input  logic             afc_rx,
  input  logic             afc_tx,
  input  logic [CW-1:0]    afc_level,
  input  logic             cts,
  input  logic             tx_push,
  input  logic [7:0]       tx_data,
  output logic             tx_full,
  output logic [CW-1:0]    tx_level,
  output logic             tx_idle,
  input  logic             rx_pop,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic [CW-1:0]    rx_level,
  input  logic             stat_rd,
  output logic             overrun,
  input  logic             rxd,
  output logic             txd,
  output logic             rts
);
  logic       tick;
  logic       tx_start, tx_busy, tx_line;
  logic       txq_empty;
  logic [7:0] txq_data;
  logic       rx_push_evt, rxq_empty, rxq_full, rx_drop;
  logic [7:0] rx_push_data;
  logic [1:0] rxd_sync;

  mu_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .div(cfg_div), .tick(tick)
  );

  mu_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(tx_push), .din(tx_data),
    .pop(tx_start), .dout(txq_data),
    .empty(txq_empty), .full(tx_full), .count(tx_level)
  );

  mu_tx #(.OSR(OSR)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .tx_en(tx_en), .len8(cfg_len8), .afc_tx(afc_tx), .cts(cts),
    .q_empty(txq_empty), .q_data(txq_data),
    .tx_start(tx_start), .busy(tx_busy), .line(tx_line)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rxd_sync <= 2'b11;
    else        rxd_sync <= {rxd_sync[0], rxd};
  end

  mu_rx #(.OSR(OSR)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .rx_en(rx_en), .len8(cfg_len8), .rxd_s(rxd_sync[1]),
    .push(rx_push_evt), .push_data(rx_push_data)
  );

  mu_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(rx_push_evt), .din(rx_push_data),
    .pop(rx_pop), .dout(rx_data),
    .empty(rxq_empty), .full(rxq_full), .count(rx_level)
  );

  assign rx_drop  = rx_push_evt && rxq_full;
  assign rx_valid = !rxq_empty;
  assign tx_idle  = txq_empty && !tx_busy;
  assign txd      = brk ? 1'b0 : tx_line;
  assign rts      = afc_rx ? (rx_level < afc_level) : rts_sw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       overrun <= 1'b0;
    else if (rx_drop) overrun <= 1'b1;
    else if (stat_rd) overrun <= 1'b0;
  end

  p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !stat_rd) |=> overrun);
  p_drop_keeps_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_drop && !rx_pop) |=> (rx_level == CW'(DEPTH)));
  p_cts_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> (!afc_tx || cts));
  p_break_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !txd);
endmodule

// File: tb/mu_serial_core_bench.sv
module mu_serial_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_div = 16'd1;
  logic        cfg_len8 = 1'b1;
  logic        tx_en = 1'b1, rx_en = 1'b1, brk = 1'b0, rts_sw = 1'b0;
  logic        afc_rx = 1'b0, afc_tx = 1'b0, cts = 1'b1;
  logic [3:0]  afc_level = 4'd3;
  logic        tx_push = 1'b0, rx_pop = 1'b0, stat_rd = 1'b0;
  logic [7:0]  tx_data = 8'h00;
  logic        tx_full, tx_idle, rx_valid, overrun, txd, rts;
  logic [3:0]  tx_level, rx_level;
  logic [7:0]  rx_data;
  logic        loop = 1'b1, rxd_drv = 1'b1;
  logic        rxd;
  int checks = 0, fails = 0, cyc = 0;

  assign rxd = loop ? txd : rxd_drv;
  always #2 clk = ~clk;

  mu_serial_core u_mu_serial_core (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_len8(cfg_len8),
    .tx_en(tx_en), .rx_en(rx_en), .brk(brk), .rts_sw(rts_sw),
    .afc_rx(afc_rx), .afc_tx(afc_tx), .afc_level(afc_level), .cts(cts),
    .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full),
    .tx_level(tx_level), .tx_idle(tx_idle), .rx_pop(rx_pop),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_level(rx_level),
    .stat_rd(stat_rd), .overrun(overrun), .rxd(rxd), .txd(txd), .rts(rts)
  );

  // {len8, divisor, byte}
  localparam logic [24:0] VEC [0:5] = '{
    {1'b1, 16'd1, 8'h55}, {1'b1, 16'd3, 8'hA5}, {1'b0, 16'd2, 8'hC3},
    {1'b1, 16'd0, 8'h01}, {1'b0, 16'd1, 8'hFF}, {1'b1, 16'd5, 8'h80}
  };

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic push_byte(input logic [7:0] b);
    @(negedge clk); tx_data = b; tx_push = 1'b1;
    @(negedge clk); tx_push = 1'b0;
  endtask

  task automatic pop_byte();
    @(negedge clk); rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
  endtask

  task automatic wait_valid(output bit got);
    got = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (rx_valid) begin got = 1'b1; break; end
    end
  endtask

  task automatic wait_level(input int lvl, output bit got);
    got = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (rx_level == 4'(lvl)) begin got = 1'b1; break; end
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (tx_idle) break;
    end
    repeat (20) @(negedge clk);
  endtask

  task automatic watch_high(input int n, output bit stayed);
    stayed = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!txd) stayed = 1'b0;
    end
  endtask

  // Push a byte and count clocks of the first low stretch on txd.
  task automatic low_width(input logic [7:0] b, output int n);
    n = 0;
    push_byte(b);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!txd) break;
    end
    while (!txd && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic drive_frame(input logic [7:0] b, input int bitclk);
    rxd_drv = 1'b0;
    repeat (bitclk) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd_drv = b[i];
      repeat (bitclk) @(negedge clk);
    end
    rxd_drv = 1'b1;
    repeat (bitclk) @(negedge clk);
  endtask

  initial begin
    bit got, stayed;
    int w;
    logic [7:0] exp_b;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(txd == 1'b1, "R1 txd", txd, 1);
    check(!rx_valid && !tx_full && tx_idle, "R1 queues", {rx_valid, tx_full, tx_idle}, 3'b001);
    check(overrun == 1'b0, "R1 overrun", overrun, 0);
    check(rts == rts_sw, "R8 rts follows sw", rts, rts_sw);
    rts_sw = 1'b1;
    @(negedge clk);
    check(rts == 1'b1, "R8 rts follows sw", rts, 1);

    // Loopback vector table: R2/R3/R5
    foreach (VEC[k]) begin
      cfg_len8 = VEC[k][24];
      cfg_div  = VEC[k][23:8];
      exp_b    = VEC[k][24] ? VEC[k][7:0] : {1'b0, VEC[k][6:0]};
      push_byte(VEC[k][7:0]);
      wait_valid(got);
      check(got && rx_data == exp_b, "R5 loopback byte (R2/R3)", rx_data, exp_b);
      pop_byte();
      wait_idle();
    end

    // R2 bit timing and LSB first, divisor 2 -> 16 clocks per bit
    rx_en = 1'b0; cfg_div = 16'd2; cfg_len8 = 1'b1;
    low_width(8'h00, w); check(w == 144, "R2 width 0x00", w, 144); wait_idle();
    low_width(8'h01, w); check(w == 16, "R2 lsb-first 0x01", w, 16); wait_idle();
    low_width(8'hFE, w); check(w == 32, "R2 lsb-first 0xFE", w, 32); wait_idle();
    // R3 7-bit mode: 0x80 sends seven zeros then stop
    cfg_len8 = 1'b0;
    low_width(8'h80, w); check(w == 128, "R3 7-bit width", w, 128); wait_idle();
    cfg_len8 = 1'b1; cfg_div = 16'd0;
    // R2 divisor 0 acts as 1 -> 8 clocks per bit
    low_width(8'h01, w); check(w == 8, "R2 div0 width", w, 8); wait_idle();
    cfg_div = 16'd1; rx_en = 1'b1;

    // R7 break
    @(negedge clk); brk = 1'b1;
    @(negedge clk); check(txd == 1'b0, "R7 break low", txd, 0);
    brk = 1'b0;
    @(negedge clk); check(txd == 1'b1, "R7 break release", txd, 1);

    // R4 / R10 transmit queue depth with transmitter off
    tx_en = 1'b0;
    for (int i = 0; i < 9; i++) push_byte(8'h20 + 8'(i));
    check(tx_full == 1'b1, "R4 tx_full", tx_full, 1);
    check(tx_level == 4'd8, "R4 tx_level", tx_level, 8);
    watch_high(100, stayed);
    check(stayed, "R10 tx disabled line high", stayed, 1);
    tx_en = 1'b1;
    wait_level(8, got);
    check(got, "R4 eight bytes delivered", rx_level, 8);
    for (int i = 0; i < 8; i++) begin
      check(rx_data == 8'h20 + 8'(i), "R5 order", rx_data, 8'h20 + i);
      pop_byte();
    end
    wait_idle();
    check(!rx_valid, "R4 ninth push dropped", rx_valid, 0);

    // R10 receiver disabled
    rx_en = 1'b0;
    push_byte(8'h3C);
    wait_idle();
    rx_en = 1'b1;
    repeat (20) @(negedge clk);
    check(!rx_valid, "R10 rx disabled ignores frame", rx_valid, 0);

    // R9 CTS hold-off
    afc_tx = 1'b1; cts = 1'b0;
    push_byte(8'h5A);
    watch_high(200, stayed);
    check(stayed && tx_level == 4'd1, "R9 held by cts", tx_level, 1);
    cts = 1'b1;
    wait_valid(got);
    check(got && rx_data == 8'h5A, "R9 sent after cts", rx_data, 8'h5A);
    pop_byte(); wait_idle(); afc_tx = 1'b0;

    // R6 / R8 overrun with automatic RTS at level 3
    afc_rx = 1'b1; afc_level = 4'd3;
    @(negedge clk);
    check(rts == 1'b1, "R8 auto rts below level", rts, 1);
    for (int i = 0; i < 8; i++) push_byte(8'h10 + 8'(i));
    wait_level(8, got);
    check(got, "R6 rx queue filled", rx_level, 8);
    check(rts == 1'b0, "R8 auto rts at level", rts, 0);
    push_byte(8'h99);
    wait_idle();
    check(overrun == 1'b1, "R6 overrun set", overrun, 1);
    check(rx_level == 4'd8, "R6 dropped byte", rx_level, 8);
    for (int i = 0; i < 8; i++) begin
      check(rx_data == 8'h10 + 8'(i), "R6 kept bytes", rx_data, 8'h10 + i);
      pop_byte();
      if (i == 5) check(rts == 1'b1, "R8 auto rts reasserts", rts, 1);
    end
    check(overrun == 1'b1, "R6 overrun sticky", overrun, 1);
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    check(overrun == 1'b0, "R6 overrun cleared", overrun, 0);
    afc_rx = 1'b0;

    // R11 short glitch, then an externally driven frame (R5)
    loop = 1'b0; cfg_div = 16'd4;
    repeat (40) @(negedge clk);
    rxd_drv = 1'b0; repeat (8) @(negedge clk); rxd_drv = 1'b1;
    repeat (400) @(negedge clk);
    check(!rx_valid, "R11 glitch rejected", rx_valid, 0);
    drive_frame(8'h96, 32);
    wait_valid(got);
    check(got && rx_data == 8'h96, "R5 external frame", rx_data, 8'h96);
    pop_byte();

    summary();
    $finish;
  end
endmodule